// File: doc/BRIEF.md
# Serial Converter Command Word Receiver

This block is the digital front end of a serial-input voltage converter. It lives in a fast system clock domain and watches four slow, externally driven lines: a serial clock, a serial data line, an active-low select and a frame marker. All four lines are first brought into the system clock domain. Their edges are then detected there, so the serial clock is treated as data and never as a clock.

A frame opens when the frame marker falls while the select is low. Data bits enter most-significant first, one on each falling serial-clock edge. The 16-bit command carries a speed flag, a power-down flag and an 8-bit converter code. The block commits a frame in one of two ways. A complete frame is committed on the first rising serial-clock edge after its sixteenth falling edge. A short frame is committed early when the frame marker rises. On a commit the block rewrites its held output latch and pulses an update strobe. The select line can be tied low for three-wire hosts. Hosts with an 8-bit word width send the command as two bytes inside one frame.

Top module: `serdac_word_rx`

## Requirements
- R1: After reset the code output, the fast flag and the power-down flag are all zero, and the update strobe is low.
- R2: A frame begins at a falling edge of the frame marker taken while the select is low. Each later falling serial-clock edge stores the data line as the next bit, starting from bit 15 and moving down to bit 0.
- R3: In the stored word, bit 14 drives the fast flag (1 = fast, 0 = slow) and bit 13 drives the power-down flag (1 = powered down). Bits 11 down to 4 form the code, with bit 11 as its MSB. Bits 15, 12 and 3 to 0 have no effect on any output.
- R4: Once sixteen bits are stored, the outputs do not change at the sixteenth falling edge. They take the new word on the next rising serial-clock edge.
- R5: If the frame marker rises while fewer than sixteen bits are stored, the word is committed at once. The stored bits stay in their top positions and every missing bit reads as zero.
- R6: While the select is high, serial-clock and frame-marker edges are ignored. A whole frame sent in that state changes no output and gives no strobe.
- R7: With the select held low at all times, frames sent one after another each commit correctly.
- R8: A pause of any length with the serial clock high, placed inside one frame-marker-low period, does not break the frame. Two separate bytes therefore make one command.
- R9: A new frame start throws away any partly received frame. The committed word then holds only bits of the new frame.
- R10: The update strobe is high for exactly one system clock per commit. The code and flag outputs change only in the cycle in which the strobe is high.
- R11: Serial-clock edges while the frame marker is high are ignored. Extra edges after a committed frame, in the same frame, are ignored too. Neither kind causes a commit.
- R12: If the frame marker rises after the sixteenth falling edge but before the next rising edge, the word is committed once at the frame-marker rise. The rising serial-clock edge that follows does not commit it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Asynchronous serial clock |
| din_i | input | 1 | Asynchronous serial data |
| cs_n_i | input | 1 | Asynchronous select, active low |
| fs_i | input | 1 | Asynchronous frame marker, active low during a frame |
| dac_code_o | output | 8 | Held converter code |
| fast_mode_o | output | 1 | Held speed flag, 1 = fast |
| power_down_o | output | 1 | Held power-down flag |
| update_o | output | 1 | One-cycle strobe on each latch write |

## Verification
The tests send several command words whose speed, power and code fields differ. Their ignored bits are set to ones in some words and zeros in others, so a wrong bit position or a leaked ignored bit shows up as a wrong output. The tests also send short frames of different lengths, to tell a left-aligned early commit from a right-aligned one. They compare a frame that is held after its sixteenth falling edge with one whose frame marker rises first; this tells the rising-edge commit apart from the marker commit and shows any double strobe. Finally, the tests send frames with the select high, a frame cut short by a new start, and serial-clock edges outside a frame. Each of these must leave the outputs and the strobe count unchanged, or must give the outputs of the new frame only.

// File: rtl/serdac_pkg.sv
// Package: shared constants for the serial converter word receiver.
// Assumes a 16-bit command word with fixed field positions.
package serdac_pkg;
    // Lane order inside the synchronizer vector.
    localparam int LANE_SCLK = 0;
    localparam int LANE_DIN  = 1;
    localparam int LANE_CSN  = 2;
    localparam int LANE_FS   = 3;
    localparam int NUM_LANES = 4;

    // Command word layout (positions used by the decoder).
    localparam int WORD_BITS  = 16;
    localparam int SPEED_POS  = 14;
    localparam int PDOWN_POS  = 13;
    localparam int CODE_MSB   = 11;
    localparam int CODE_BITS  = 8;
endpackage

// File: rtl/serdac_sync.sv
// Module: serdac_sync
// Brings a vector of asynchronous lines into the clk domain through a chain
// of STAGES flops per lane and reports level, rising and falling edges.
// Assumes each line is stable for several clk periods between changes.
// Lanes reset to IDLE so no false edge is seen at reset release.
module serdac_sync #(
    parameter int              LANES  = 4,
    parameter int              STAGES = 2,
    parameter logic [LANES-1:0] IDLE  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] level_o,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the raw line through the chain and keep the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{IDLE[g]}};
                prev  <= IDLE[g];
            end else begin
                chain <= {chain[STAGES-2:0], raw_i[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign level_o[g] = chain[STAGES-1];
        assign rise_o[g]  = chain[STAGES-1] & ~prev;
        assign fall_o[g]  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/serdac_frame.sv
// Module: serdac_frame
// Frame tracker and shift register. Opens a frame on a frame-marker fall,
// stores one bit per serial-clock fall (MSB first), and raises commit for one
// cycle on the rise after the last bit or on an early frame-marker rise.
// Assumes synchronized, single-cycle edge pulses; all edges are ignored
// while the select is high.
module serdac_frame #(
    parameter int WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n_s,
    input  logic                 fs_s,
    input  logic                 din_s,
    input  logic                 fs_fall,
    input  logic                 fs_rise,
    input  logic                 sclk_fall,
    input  logic                 sclk_rise,
    output logic                 commit_o,
    output logic [WORD_BITS-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    logic                 active;
    logic                 pending;
    logic [CNT_W-1:0]     cnt;
    logic [WORD_BITS-1:0] shreg;
    logic [CNT_W-1:0]     bit_idx;
    logic                 sel;
    logic                 take_bit;
    logic                 early_commit;
    logic                 late_commit;

    assign sel          = ~cs_n_s;
    assign bit_idx      = LAST - cnt;
    assign take_bit     = sel && !fs_fall && active && !fs_rise && sclk_fall && !fs_s;
    assign early_commit = sel && !fs_fall && active && fs_rise;
    assign late_commit  = sel && !fs_fall && pending && (sclk_rise || fs_rise);

    // Track the frame state, the bit counter and the stored bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            pending <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
        end else if (sel) begin
            if (fs_fall) begin
                active  <= 1'b1;
                pending <= 1'b0;
                cnt     <= '0;
                shreg   <= '0;
            end else if (early_commit) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (take_bit) begin
                shreg[bit_idx] <= din_s;
                if (cnt == LAST) begin
                    active  <= 1'b0;
                    pending <= 1'b1;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (late_commit) begin
                pending <= 1'b0;
            end
        end
    end

    assign commit_o = early_commit || late_commit;
    assign word_o   = shreg;

    // R4: a frame is never both collecting bits and awaiting its commit.
    p_state_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && pending));

    // R6: with the select high nothing is stored.
    p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(shreg));

    // R12: a commit closes the frame, so no second commit follows.
    p_single_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !(active || pending));

    // R2: stored bits only change on a serial-clock fall or a frame start.
    p_shift_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !fs_fall) |=> $stable(shreg));
endmodule

// File: rtl/serdac_latch.sv
// Module: serdac_latch
// Decodes a committed command word into the speed flag, the power-down flag
// and the code, holds them, and pulses update for one cycle per write.
// Assumes commit is a one-cycle pulse; field positions come from the package.
module serdac_latch
    import serdac_pkg::*;
#(
    parameter int WBITS = WORD_BITS,
    parameter int CBITS = CODE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [WBITS-1:0] word_i,
    output logic [CBITS-1:0] code_o,
    output logic             fast_o,
    output logic             pdown_o,
    output logic             update_o
);
    localparam int CODE_LSB = CODE_MSB - CBITS + 1;
    localparam logic [WBITS-1:0] USED_MASK =
        (WBITS'(1) << SPEED_POS) | (WBITS'(1) << PDOWN_POS) |
        (((WBITS'(1) << CBITS) - WBITS'(1)) << CODE_LSB);

    logic unused_word_bits;
    assign unused_word_bits = ^(word_i & ~USED_MASK);

    // Write the held fields on commit and raise the strobe for that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o   <= '0;
            fast_o   <= 1'b0;
            pdown_o  <= 1'b0;
            update_o <= 1'b0;
        end else begin
            update_o <= commit_i;
            if (commit_i) begin
                code_o  <= word_i[CODE_MSB -: CBITS];
                fast_o  <= word_i[SPEED_POS];
                pdown_o <= word_i[PDOWN_POS];
            end
        end
    end

    // R10: the strobe never lasts two cycles.
    p_strobe_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R10: without a commit the held outputs keep their values.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable({code_o, fast_o, pdown_o}));

    // R10: every commit is followed by the strobe.
    p_commit_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> update_o);
endmodule

// File: rtl/serdac_word_rx.sv
// Module: serdac_word_rx
// Top of the serial converter word receiver: synchronizes the four serial
// lines, tracks frames and shifts bits, then decodes and holds the command.
// Assumes the serial lines change slowly compared with clk.
module serdac_word_rx
    import serdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 din_i,
    input  logic                 cs_n_i,
    input  logic                 fs_i,
    output logic [CODE_BITS-1:0] dac_code_o,
    output logic                 fast_mode_o,
    output logic                 power_down_o,
    output logic                 update_o
);
    logic [NUM_LANES-1:0] raw, lvl, rise, fall;
    logic                 commit;
    logic [WORD_BITS-1:0] word;
    logic                 unused_edges;

    // Gather the raw lines into lane order.
    always_comb begin
        raw            = '0;
        raw[LANE_SCLK] = sclk_i;
        raw[LANE_DIN]  = din_i;
        raw[LANE_CSN]  = cs_n_i;
        raw[LANE_FS]   = fs_i;
    end

    assign unused_edges = ^{rise[LANE_DIN], fall[LANE_DIN], rise[LANE_CSN],
                            fall[LANE_CSN], lvl[LANE_SCLK]};

    serdac_sync #(
        .LANES  (NUM_LANES),
        .STAGES (SYNC_STAGES),
        .IDLE   ('1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    serdac_frame #(
        .WORD_BITS (WORD_BITS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (lvl[LANE_CSN]),
        .fs_s      (lvl[LANE_FS]),
        .din_s     (lvl[LANE_DIN]),
        .fs_fall   (fall[LANE_FS]),
        .fs_rise   (rise[LANE_FS]),
        .sclk_fall (fall[LANE_SCLK]),
        .sclk_rise (rise[LANE_SCLK]),
        .commit_o  (commit),
        .word_o    (word)
    );

    serdac_latch #(
        .WBITS (WORD_BITS),
        .CBITS (CODE_BITS)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (word),
        .code_o   (dac_code_o),
        .fast_o   (fast_mode_o),
        .pdown_o  (power_down_o),
        .update_o (update_o)
    );
endmodule

// File: tb/serdac_word_rx_tb.sv
// Directed bench for serdac_word_rx: one task per scenario.
module serdac_word_rx_tb;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1, din = 1'b0, cs_n = 1'b1, fs = 1'b1;
    logic [7:0] code;
    logic       fast, pd, upd;
    int         total = 0, fails = 0, pulses = 0, run = 0, max_run = 0;

    always #2.5 clk = ~clk;

    serdac_word_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .din_i(din), .cs_n_i(cs_n),
        .fs_i(fs), .dac_code_o(code), .fast_mode_o(fast),
        .power_down_o(pd), .update_o(upd)
    );

    // Count strobe pulses and the longest strobe run.
    always @(posedge clk) begin
        if (rst_n && upd) begin
            if (run == 0) pulses <= pulses + 1;
            run <= run + 1;
            if (run + 1 > max_run) max_run <= run + 1;
        end else begin
            run <= 0;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int c, input int f, input int p);
        chk({req, " code"}, int'(code), c);
        chk({req, " fast"}, int'(fast), f);
        chk({req, " pdown"}, int'(pd), p);
    endtask

    task automatic fs_down();
        fs = 1'b0; idle(HALF);
    endtask

    task automatic fs_up();
        fs = 1'b1; idle(HALF);
    endtask

    // Send n bits from the top of w; ends with the clock low after the last fall.
    task automatic clock_bits(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            din = w[15-i]; idle(HALF);
            sclk = 1'b0;   idle(HALF);
            if (i != n - 1) begin
                sclk = 1'b1;
            end
        end
    endtask

    task automatic sclk_up();
        sclk = 1'b1; idle(HALF + 4);
    endtask

    task automatic full_frame(input logic [15:0] w);
        fs_down(); clock_bits(w, 16); sclk_up(); fs_up();
    endtask

    task automatic t_reset_r1();
        chk_out("R1", 0, 0, 0);
        chk("R1 strobe", int'(upd), 0);
    endtask

    task automatic t_decode_r3();
        int p0;
        cs_n = 1'b0; idle(HALF);
        p0 = pulses;
        full_frame(16'h4AB0);
        chk_out("R2 R3 w4AB0", 'hAB, 1, 0);
        full_frame(16'hBCD5);
        chk_out("R3 wBCD5", 'hCD, 0, 1);
        full_frame(16'h6FF0);
        chk_out("R3 w6FF0", 'hFF, 1, 1);
        full_frame(16'h900F);
        chk_out("R3 w900F ignored bits", 0, 0, 0);
        chk("R10 pulses per frame", pulses - p0, 4);
    endtask

    task automatic t_rise_commit_r4();
        int p0;
        full_frame(16'h0120);
        p0 = pulses;
        fs_down(); clock_bits(16'h6A50, 16); idle(20);
        chk_out("R4 held at 16th fall", 'h12, 0, 0);
        chk("R4 no strobe yet", pulses - p0, 0);
        sclk_up();
        chk_out("R4 after rise", 'hA5, 1, 1);
        fs_up();
        chk("R4 one strobe", pulses - p0, 1);
    endtask

    task automatic t_early_r5();
        int p0 = pulses;
        fs_down(); clock_bits(16'h4E7F, 9); fs_up();
        chk_out("R5 nine bits", 'hE0, 1, 0);
        sclk_up();
        fs_down(); clock_bits(16'h7FFF, 3); fs_up();
        chk_out("R5 three bits", 0, 1, 1);
        sclk_up();
        chk("R5 strobes", pulses - p0, 2);
    endtask

    task automatic t_cs_high_r6();
        int p0 = pulses;
        full_frame(16'h2340);
        p0 = pulses;
        cs_n = 1'b1; idle(HALF);
        full_frame(16'h6FF0);
        fs_down(); clock_bits(16'hFFFF, 5); fs_up(); sclk_up();
        chk_out("R6 select high", 'h34, 0, 1);
        chk("R6 no strobe", pulses - p0, 0);
        cs_n = 1'b0; idle(HALF);
    endtask

    task automatic t_three_wire_r7();
        full_frame(16'h4010);
        chk_out("R7 first", 'h01, 1, 0);
        full_frame(16'h2FE0);
        chk_out("R7 second", 'hFE, 0, 1);
    endtask

    task automatic t_two_bytes_r8();
        int p0 = pulses;
        fs_down(); clock_bits(16'h4C30, 8); sclk_up(); idle(300);
        chk("R8 no commit mid-frame", pulses - p0, 0);
        clock_bits(16'h3000, 8); sclk_up(); fs_up();
        chk_out("R8 two bytes", 'hC3, 1, 0);
        chk("R8 one strobe", pulses - p0, 1);
    endtask

    task automatic t_abort_r9();
        int p0 = pulses;
        fs_down(); clock_bits(16'hFFFF, 6); sclk_up();
        cs_n = 1'b1; idle(HALF); fs_up();
        cs_n = 1'b0; idle(HALF);
        full_frame(16'h0120);
        chk_out("R9 restarted frame", 'h12, 0, 0);
        chk("R9 one strobe", pulses - p0, 1);
    endtask

    task automatic t_stray_r11();
        int p0 = pulses;
        clock_bits(16'hFFFF, 5); sclk_up();
        chk("R11 fs high no strobe", pulses - p0, 0);
        fs_down(); clock_bits(16'h6780, 16); sclk_up();
        clock_bits(16'hFFFF, 6); sclk_up(); fs_up();
        chk_out("R11 extra clocks", 'h78, 1, 1);
        chk("R11 one strobe", pulses - p0, 1);
    endtask

    task automatic t_fs_commit_r12();
        int p0 = pulses;
        fs_down(); clock_bits(16'h45A0, 16); fs_up();
        chk_out("R12 at fs rise", 'h5A, 1, 0);
        sclk_up();
        chk("R12 one strobe", pulses - p0, 1);
        chk("R10 strobe width", max_run, 1);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(10);
        t_reset_r1();
        t_decode_r3();
        t_rise_commit_r4();
        t_early_r5();
        t_cs_high_r6();
        t_three_wire_r7();
        t_two_bytes_r8();
        t_abort_r9();
        t_stray_r11();
        t_fs_commit_r12();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #500000;
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule